// File: doc/BRIEF.md
# Interrupt Vector Ring Consumer

This block drains a circular ring of interrupt vectors that a producer fills in memory. It polls a writeback word that holds the producer's byte write pointer, removes the overflow flag carried in that word, and masks the pointer to the ring size. When the flag is set, the consumer gives up on the entries that were overwritten. It moves its read pointer to the slot just past the write pointer and asks the producer side to clear the overflow condition.

For every vector between the read and write pointers, the block reads four consecutive 32-bit words through a simple request/response memory port. It unpacks the source, payload, ring, VM and process-address-space identifiers and presents them on a valid/ready stream. When the ring looks empty, the block samples the writeback word one more time. Only if no new work has appeared does it publish the final read pointer. Publication goes to a register strobe, or, in doorbell mode, to a memory-slot write paired with a doorbell write at a configured index.

Top module: `ivr_consumer`

## Requirements
- R1: After reset the read pointer is 0. The stream output is not valid, and there is no memory request, no overflow-clear pulse and no publish strobe.
- R2: Bit 0 of the writeback word is the overflow flag. The write pointer is the writeback word with bit 0 cleared and ANDed with (ring bytes - 1). The consumer drains until the read pointer equals that value, so bits above the ring size are ignored.
- R3: When the sampled overflow flag is 1, the read pointer becomes (write pointer + 16) mod ring bytes, and ovf_clr pulses high for exactly one cycle.
- R4: Each vector is fetched as four single-cycle requests, one request per response, at word addresses (read pointer >> 2) + 0..3. Addresses wrap within the ring.
- R5: Decoded fields are: source id = word0[7:0], source data = word1[27:0], ring id = word2[7:0], VM id = word2[15:8], PASID = word2[31:16].
- R6: Each accepted vector advances the read pointer by 16 bytes modulo the ring size.
- R7: While iv_valid is high and iv_ready is low, all decoded fields stay unchanged. No memory request is issued while iv_valid is high.
- R8: After draining, the write pointer is sampled once more before publishing. One drain produces exactly one publish, which carries the final read pointer. An idle ring publishes nothing.
- R9: With cfg_use_db = 0, a publish is a one-cycle pub_reg_we pulse with pub_rptr set to the read pointer.
- R10: With cfg_use_db = 1, a publish pulses pub_slot_we and pub_db_we in the same cycle, with pub_db_idx = cfg_db_idx and no pub_reg_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_use_db | input | 1 | 1 selects doorbell publication, 0 selects register publication |
| cfg_db_idx | input | DB_W | Doorbell index used in doorbell mode |
| wb_wptr | input | 32 | Writeback word: byte write pointer, bit 0 = overflow flag |
| mem_req | output | 1 | One-cycle ring read request |
| mem_addr | output | RING_LOG2-2 | Ring word address of the request |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| iv_valid | output | 1 | Decoded vector valid |
| iv_ready | input | 1 | Downstream accepts the vector |
| iv_src_id | output | 8 | Source identifier |
| iv_src_data | output | 28 | Source payload |
| iv_ring_id | output | 8 | Ring identifier |
| iv_vm_id | output | 8 | VM identifier |
| iv_pasid | output | 16 | Process address space identifier |
| ovf_clr | output | 1 | One-cycle request to clear the producer overflow flag |
| pub_rptr | output | 32 | Published byte read pointer |
| pub_reg_we | output | 1 | Register publish strobe |
| pub_slot_we | output | 1 | Memory-slot publish strobe (doorbell mode) |
| pub_db_we | output | 1 | Doorbell write strobe |
| pub_db_idx | output | DB_W | Doorbell index of the write |

## Verification
The overflow resynchronisation and the publish decision meet in one cycle, when the extra sample taken after a drain is the one that carries the overflow flag. The bench provokes this by raising the flag with a new write pointer while the first vectors are still being drained. It then checks that no publish of the stale pointer appears, and that the stream continues from the slot after the new write pointer. A second drain is checked in the same way: a late write-pointer bump during draining must fold into a single publish with the final value.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int IV_WORDS = 4;
    localparam int IV_BYTES = 16;
    localparam int OVF_BIT  = 0;

    typedef enum logic [2:0] {
        ST_SAMPLE = 3'd0,
        ST_CMP    = 3'd1,
        ST_REQ    = 3'd2,
        ST_WAIT   = 3'd3,
        ST_OUT    = 3'd4,
        ST_PUB    = 3'd5
    } ivr_state_e;

    typedef struct packed {
        logic [7:0]  src_id;
        logic [27:0] src_data;
        logic [7:0]  ring_id;
        logic [7:0]  vm_id;
        logic [15:0] pasid;
    } iv_fields_t;

endpackage

// File: rtl/ivr_wptr_clean.sv
module ivr_wptr_clean #(
    parameter int RING_LOG2 = 8
) (
    input  logic [31:0]          raw,
    output logic [RING_LOG2-1:0] clean,
    output logic                 ovf,
    output logic [RING_LOG2-1:0] resync
);
    import ivr_pkg::*;

    logic [31:0] unused_hi;

    always_comb begin
        ovf             = raw[OVF_BIT];
        clean           = raw[RING_LOG2-1:0];
        clean[OVF_BIT]  = 1'b0;
        resync          = clean + RING_LOG2'(IV_BYTES);
        unused_hi       = raw;
    end

endmodule

// File: rtl/ivr_iv_decode.sv
module ivr_iv_decode (
    input  logic [3:0][31:0]    words,
    output ivr_pkg::iv_fields_t fields
);
    logic [67:0] unused_bits;

    always_comb begin
        fields.src_id   = words[0][7:0];
        fields.src_data = words[1][27:0];
        fields.ring_id  = words[2][7:0];
        fields.vm_id    = words[2][15:8];
        fields.pasid    = words[2][31:16];
        unused_bits     = {words[3], words[0][31:8], words[1][31:28]};
    end

endmodule

// File: rtl/ivr_rptr_publish.sv
module ivr_rptr_publish #(
    parameter int RING_LOG2 = 8,
    parameter int DB_W      = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  logic                 use_db,
    input  logic [DB_W-1:0]      db_idx_in,
    input  logic [RING_LOG2-1:0] rptr_in,
    output logic [31:0]          pub_rptr,
    output logic                 pub_reg_we,
    output logic                 pub_slot_we,
    output logic                 pub_db_we,
    output logic [DB_W-1:0]      pub_db_idx
);
    typedef struct packed {
        logic                 reg_we;
        logic                 slot_we;
        logic                 db_we;
        logic [RING_LOG2-1:0] val;
        logic [DB_W-1:0]      idx;
    } pub_t;

    pub_t pub_d, pub_q;

    always_comb begin
        pub_d         = pub_q;
        pub_d.reg_we  = 1'b0;
        pub_d.slot_we = 1'b0;
        pub_d.db_we   = 1'b0;
        if (fire) begin
            pub_d.val = rptr_in;
            pub_d.idx = db_idx_in;
            if (use_db) begin
                pub_d.slot_we = 1'b1;
                pub_d.db_we   = 1'b1;
            end else begin
                pub_d.reg_we  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pub_q <= '0;
        else        pub_q <= pub_d;
    end

    assign pub_rptr    = {{(32-RING_LOG2){1'b0}}, pub_q.val};
    assign pub_reg_we  = pub_q.reg_we;
    assign pub_slot_we = pub_q.slot_we;
    assign pub_db_we   = pub_q.db_we;
    assign pub_db_idx  = pub_q.idx;

endmodule

// File: rtl/ivr_consumer.sv
module ivr_consumer #(
    parameter int RING_LOG2 = 8,
    parameter int DB_W      = 10,
    localparam int WIDX_W   = RING_LOG2 - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_use_db,
    input  logic [DB_W-1:0]   cfg_db_idx,
    input  logic [31:0]       wb_wptr,
    output logic              mem_req,
    output logic [WIDX_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              iv_valid,
    input  logic              iv_ready,
    output logic [7:0]        iv_src_id,
    output logic [27:0]       iv_src_data,
    output logic [7:0]        iv_ring_id,
    output logic [7:0]        iv_vm_id,
    output logic [15:0]       iv_pasid,
    output logic              ovf_clr,
    output logic [31:0]       pub_rptr,
    output logic              pub_reg_we,
    output logic              pub_slot_we,
    output logic              pub_db_we,
    output logic [DB_W-1:0]   pub_db_idx
);
    import ivr_pkg::*;

    typedef struct packed {
        ivr_state_e           st;
        logic [RING_LOG2-1:0] rptr;
        logic [RING_LOG2-1:0] wptr;
        logic [1:0]           cnt;
        logic                 resampled;
        logic                 dirty;
        logic                 ovf_clr;
        logic [3:0][31:0]     words;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [RING_LOG2-1:0] w_clean;
    logic [RING_LOG2-1:0] w_resync;
    logic                 w_ovf;
    logic                 pub_fire;
    iv_fields_t           fields;

    ivr_wptr_clean #(.RING_LOG2(RING_LOG2)) u_wclean (
        .raw    (wb_wptr),
        .clean  (w_clean),
        .ovf    (w_ovf),
        .resync (w_resync)
    );

    ivr_iv_decode u_decode (
        .words  (ctl_q.words),
        .fields (fields)
    );

    ivr_rptr_publish #(.RING_LOG2(RING_LOG2), .DB_W(DB_W)) u_publish (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (pub_fire),
        .use_db      (cfg_use_db),
        .db_idx_in   (cfg_db_idx),
        .rptr_in     (ctl_q.rptr),
        .pub_rptr    (pub_rptr),
        .pub_reg_we  (pub_reg_we),
        .pub_slot_we (pub_slot_we),
        .pub_db_we   (pub_db_we),
        .pub_db_idx  (pub_db_idx)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.ovf_clr = 1'b0;
        pub_fire      = 1'b0;
        unique case (ctl_q.st)
            ST_SAMPLE: begin
                ctl_d.wptr = w_clean;
                if (w_ovf) begin
                    ctl_d.rptr    = w_resync;
                    ctl_d.ovf_clr = 1'b1;
                end
                ctl_d.st = ST_CMP;
            end
            ST_CMP: begin
                if (ctl_q.rptr != ctl_q.wptr) begin
                    ctl_d.cnt       = 2'd0;
                    ctl_d.resampled = 1'b0;
                    ctl_d.st        = ST_REQ;
                end else if (!ctl_q.resampled) begin
                    ctl_d.resampled = 1'b1;
                    ctl_d.st        = ST_SAMPLE;
                end else if (ctl_q.dirty) begin
                    ctl_d.st        = ST_PUB;
                end else begin
                    ctl_d.resampled = 1'b0;
                    ctl_d.st        = ST_SAMPLE;
                end
            end
            ST_REQ: begin
                ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    ctl_d.words[ctl_q.cnt] = mem_rdata;
                    if (ctl_q.cnt == 2'd3) begin
                        ctl_d.st = ST_OUT;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 2'd1;
                        ctl_d.st  = ST_REQ;
                    end
                end
            end
            ST_OUT: begin
                if (iv_ready) begin
                    ctl_d.rptr  = ctl_q.rptr + RING_LOG2'(IV_BYTES);
                    ctl_d.dirty = 1'b1;
                    ctl_d.st    = ST_CMP;
                end
            end
            ST_PUB: begin
                pub_fire        = 1'b1;
                ctl_d.dirty     = 1'b0;
                ctl_d.resampled = 1'b0;
                ctl_d.st        = ST_SAMPLE;
            end
            default: ctl_d.st = ST_SAMPLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mem_req     = (ctl_q.st == ST_REQ);
    assign mem_addr    = ctl_q.rptr[RING_LOG2-1:2] + WIDX_W'(ctl_q.cnt);
    assign iv_valid    = (ctl_q.st == ST_OUT);
    assign iv_src_id   = fields.src_id;
    assign iv_src_data = fields.src_data;
    assign iv_ring_id  = fields.ring_id;
    assign iv_vm_id    = fields.vm_id;
    assign iv_pasid    = fields.pasid;
    assign ovf_clr     = ctl_q.ovf_clr;

endmodule

// File: rtl/ivr_consumer_chk.sv
module ivr_consumer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        iv_valid,
    input logic        iv_ready,
    input logic [7:0]  iv_src_id,
    input logic [27:0] iv_src_data,
    input logic [7:0]  iv_ring_id,
    input logic [7:0]  iv_vm_id,
    input logic [15:0] iv_pasid,
    input logic        ovf_clr,
    input logic        pub_reg_we,
    input logic        pub_slot_we,
    input logic        pub_db_we
);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iv_valid && !iv_ready |=> iv_valid && $stable(iv_src_id) && $stable(iv_src_data)
            && $stable(iv_ring_id) && $stable(iv_vm_id) && $stable(iv_pasid))
        else $error("p_hold_r7");

    p_nofetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iv_valid |-> !mem_req)
        else $error("p_nofetch_r7");

    p_single_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req)
        else $error("p_single_req_r4");

    p_ovf_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr |=> !ovf_clr)
        else $error("p_ovf_pulse_r3");

    p_db_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pub_db_we |-> pub_slot_we && !pub_reg_we)
        else $error("p_db_pair_r10");

    p_slot_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pub_slot_we |-> pub_db_we)
        else $error("p_slot_pair_r10");

    p_reg_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pub_reg_we |=> !pub_reg_we)
        else $error("p_reg_pulse_r9");

    p_pub_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pub_reg_we || pub_db_we) |-> !iv_valid && !mem_req)
        else $error("p_pub_quiet_r8");

endmodule

bind ivr_consumer ivr_consumer_chk u_chk (.*);

// File: tb/tb_ivr_consumer.sv
module tb_ivr_consumer;
    localparam int CLK_PERIOD = 10;
    localparam int RING_LOG2  = 8;
    localparam int DB_W       = 10;
    localparam int WIDX_W     = RING_LOG2 - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_use_db = 1'b0;
    logic [DB_W-1:0]   cfg_db_idx = '0;
    logic [31:0]       wb_wptr = '0;
    logic              mem_req;
    logic [WIDX_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              iv_valid;
    logic              iv_ready = 1'b0;
    logic [7:0]        iv_src_id;
    logic [27:0]       iv_src_data;
    logic [7:0]        iv_ring_id;
    logic [7:0]        iv_vm_id;
    logic [15:0]       iv_pasid;
    logic              ovf_clr;
    logic [31:0]       pub_rptr;
    logic              pub_reg_we;
    logic              pub_slot_we;
    logic              pub_db_we;
    logic [DB_W-1:0]   pub_db_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivr_consumer #(.RING_LOG2(RING_LOG2), .DB_W(DB_W)) dut (.*);

    typedef struct {
        bit [7:0]  s;
        bit [27:0] d;
        bit [7:0]  r;
        bit [7:0]  v;
        bit [15:0] p;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mem [0:63];
    int          slot_seed [0:15];

    int n_tests = 0, n_fail = 0;
    int cyc = 0, acc_cnt = 0, rd_cnt = 0, ovf_seen = 0, fetch_viol = 0;
    int pub_cnt = 0, pub_reg_n = 0, pub_db_n = 0, pub_slot_n = 0;
    logic [31:0]     last_pub = '0;
    logic [DB_W-1:0] last_idx = '0;
    bit              rsp_pend = 0;
    logic [WIDX_W-1:0] rsp_addr = '0;
    bit              held = 0;
    exp_t            held_v;
    bit              finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Requirement R5 defines the expected fields from the raw words.
    task automatic put_vec(input int slot, input int seed);
        logic [31:0] w0, w1, w2, w3;
        exp_t e;
        w0 = 32'hDEAD_0000 | (32'(seed) * 32'd7);
        w1 = 32'hF000_0000 | (32'(seed) * 32'h0001_3579);
        w2 = 32'(seed) * 32'h9E37_79B9;
        w3 = ~32'(seed);
        mem[slot*4+0] = w0;
        mem[slot*4+1] = w1;
        mem[slot*4+2] = w2;
        mem[slot*4+3] = w3;
        slot_seed[slot] = seed;
        e.s = w0[7:0];
        e.d = w1[27:0];
        e.r = w2[7:0];
        e.v = w2[15:8];
        e.p = w2[31:16];
        sb.push_back(e);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_pub(input int start, input string req);
        int t = 0;
        while (pub_cnt == start && t < 5000) begin
            tick(1);
            t++;
        end
        chk(pub_cnt > start, req, "publish seen", 32'(pub_cnt), 32'(start + 1));
    endtask

    // Monitor, memory model and ready driver, all at the falling edge.
    always @(negedge clk) begin
        cyc++;
        iv_ready = ((cyc % 5) != 2) && ((cyc % 5) != 3);
        if (rsp_pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[rsp_addr];
            rsp_pend   = 0;
        end else begin
            mem_rvalid = 1'b0;
        end
        if (rst_n) begin
            if (mem_req) begin
                rd_cnt++;
                rsp_pend = 1;
                rsp_addr = mem_addr;
                if (iv_valid) fetch_viol++;
            end
            if (iv_valid && held) begin
                chk(iv_src_id == held_v.s && iv_src_data == held_v.d && iv_ring_id == held_v.r
                    && iv_vm_id == held_v.v && iv_pasid == held_v.p,
                    "R7", "fields held under stall", {iv_src_id, 24'd0}, {held_v.s, 24'd0});
            end
            held = 0;
            if (iv_valid && !iv_ready) begin
                held     = 1;
                held_v.s = iv_src_id;
                held_v.d = iv_src_data;
                held_v.r = iv_ring_id;
                held_v.v = iv_vm_id;
                held_v.p = iv_pasid;
            end
            if (iv_valid && iv_ready) begin
                acc_cnt++;
                if (sb.size() == 0) begin
                    chk(0, "R2", "unexpected vector", {24'd0, iv_src_id}, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(iv_src_id == e.s, "R5", "src_id", {24'd0, iv_src_id}, {24'd0, e.s});
                    chk(iv_src_data == e.d, "R5", "src_data", {4'd0, iv_src_data}, {4'd0, e.d});
                    chk(iv_ring_id == e.r && iv_vm_id == e.v && iv_pasid == e.p, "R5",
                        "ring/vm/pasid", {iv_pasid, iv_vm_id, iv_ring_id}, {e.p, e.v, e.r});
                end
            end
            if (ovf_clr) ovf_seen++;
            if (pub_reg_we || pub_slot_we || pub_db_we) begin
                pub_cnt++;
                last_pub = pub_rptr;
                last_idx = pub_db_idx;
                if (pub_reg_we)  pub_reg_n++;
                if (pub_db_we)   pub_db_n++;
                if (pub_slot_we) pub_slot_n++;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p0, r0, a0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) slot_seed[i] = 0;

        // R1: reset state
        tick(3);
        chk(!iv_valid, "R1", "iv_valid in reset", 32'(iv_valid), 0);
        chk(!mem_req, "R1", "mem_req in reset", 32'(mem_req), 0);
        chk(!ovf_clr, "R1", "ovf_clr in reset", 32'(ovf_clr), 0);
        chk(!(pub_reg_we | pub_slot_we | pub_db_we), "R1", "publish in reset", 32'(pub_reg_we), 0);
        rst_n = 1'b1;
        tick(40);
        chk(pub_cnt == 0 && rd_cnt == 0, "R8", "idle ring quiet", 32'(pub_cnt + rd_cnt), 0);

        // R9/R4/R6: three vectors, register mode
        p0 = pub_cnt; r0 = rd_cnt;
        put_vec(0, 11); put_vec(1, 12); put_vec(2, 13);
        wb_wptr = 32'd48;
        wait_pub(p0, "R9");
        tick(2);
        chk(last_pub == 32'd48, "R6", "rptr after 3 vectors", last_pub, 32'd48);
        chk(pub_reg_n == 1 && pub_db_n == 0, "R9", "register strobe only", 32'(pub_reg_n), 1);
        chk(rd_cnt - r0 == 12, "R4", "word reads", 32'(rd_cnt - r0), 32'd12);
        chk(sb.size() == 0, "R2", "drained all", 32'(sb.size()), 0);

        // R10: doorbell mode
        cfg_use_db = 1'b1;
        cfg_db_idx = 10'h2A5;
        p0 = pub_cnt;
        put_vec(3, 21); put_vec(4, 22);
        wb_wptr = 32'd80;
        wait_pub(p0, "R10");
        tick(2);
        chk(last_pub == 32'd80, "R10", "doorbell rptr", last_pub, 32'd80);
        chk(pub_db_n == 1 && pub_slot_n == 1 && pub_reg_n == 1, "R10", "slot+doorbell strobes",
            32'(pub_db_n + pub_slot_n), 32'd2);
        chk(last_idx == 10'h2A5, "R10", "doorbell index", 32'(last_idx), 32'h2A5);

        // R6/R4: wrap around the ring end
        cfg_use_db = 1'b0;
        p0 = pub_cnt; r0 = rd_cnt;
        for (int s = 5; s < 16; s++) put_vec(s, 30 + s);
        put_vec(0, 50); put_vec(1, 51);
        wb_wptr = 32'd32;
        wait_pub(p0, "R6");
        tick(2);
        chk(last_pub == 32'd32, "R6", "rptr after wrap", last_pub, 32'd32);
        chk(rd_cnt - r0 == 52, "R4", "wrap word reads", 32'(rd_cnt - r0), 32'd52);
        chk(sb.size() == 0, "R6", "wrap drained", 32'(sb.size()), 0);

        // R3/R8: overflow reported on the re-sample after a drain
        p0 = pub_cnt; a0 = acc_cnt;
        put_vec(2, 60); put_vec(3, 61);
        wb_wptr = 32'd64;
        while (acc_cnt == a0) tick(1);
        for (int s = 7; s < 16; s++) put_vec(s, 70 + s);
        put_vec(0, 90); put_vec(1, 91);
        put_vec(2, slot_seed[2]); put_vec(3, slot_seed[3]);
        put_vec(4, 94); put_vec(5, 95);
        wb_wptr = 32'd96 | 32'd1;
        while (ovf_seen == 0 && pub_cnt == p0) tick(1);
        chk(pub_cnt == p0, "R8", "no stale publish before overflow", 32'(pub_cnt), 32'(p0));
        wb_wptr = 32'd96;
        wait_pub(p0, "R3");
        tick(2);
        chk(ovf_seen == 1, "R3", "single overflow clear", 32'(ovf_seen), 1);
        chk(last_pub == 32'd96, "R3", "rptr after resync", last_pub, 32'd96);
        chk(pub_cnt == p0 + 1, "R8", "one publish", 32'(pub_cnt), 32'(p0 + 1));
        chk(sb.size() == 0, "R3", "resync drained", 32'(sb.size()), 0);

        // R8: late vectors fold into one publish
        p0 = pub_cnt; a0 = acc_cnt;
        put_vec(6, 101); put_vec(7, 102);
        wb_wptr = 32'd128;
        while (acc_cnt == a0) tick(1);
        put_vec(8, 103); put_vec(9, 104);
        wb_wptr = 32'd160;
        wait_pub(p0, "R8");
        tick(60);
        chk(last_pub == 32'd160, "R8", "final rptr", last_pub, 32'd160);
        chk(pub_cnt == p0 + 1, "R8", "single publish", 32'(pub_cnt), 32'(p0 + 1));
        chk(sb.size() == 0, "R8", "late drained", 32'(sb.size()), 0);

        // R2: upper bits ignored
        p0 = pub_cnt;
        put_vec(10, 120);
        wb_wptr = 32'h1234_56B0;
        wait_pub(p0, "R2");
        tick(2);
        chk(last_pub == 32'd176, "R2", "masked wptr", last_pub, 32'd176);
        chk(sb.size() == 0, "R2", "masked drained", 32'(sb.size()), 0);

        chk(fetch_viol == 0, "R7", "no fetch while valid", 32'(fetch_viol), 0);
        chk(ovf_seen == 1, "R3", "no extra overflow clear", 32'(ovf_seen), 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule